// File: doc/BRIEF.md
# Serial Gamepad Poller

This block is the host side of a three-wire link to a twelve-button gamepad. The gamepad keeps its buttons in an internal parallel-in, serial-out register. The host takes a snapshot of the buttons with a high strobe on a latch wire. It then shifts the bits out by toggling a clock wire that idles high. The gamepad returns each bit on a data wire, and a low level on that wire means the button is pressed.

A free-running period timer starts a read at a configurable rate, 60 per second by default. A start input can also launch a read at once. For each read the block does four things in order:

- It drives the latch pulse.
- It waits a gap.
- It issues sixteen clock pulses.
- It samples the data wire through a two-flop synchronizer.

The first bit is already on the wire when the latch falls, so it is taken just before the first clock falling edge. Each later bit is taken just before its own falling edge. The collected bits are inverted so that 1 means pressed, and the word is presented with a one-cycle valid strobe. All timing is given in microseconds and converted to cycle counts from the system clock frequency, which must be 1 MHz or more.

Top module: `gamepad_poller`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release: pad_latch_o=0, pad_clk_o=1, busy_o=0, valid_o=0, buttons_o=0.
- R2: pad_latch_o is high for exactly LATCH_US microseconds (LATCH_US*CLK_HZ/1e6 cycles). The pulse starts in the cycle after the edge that accepted a trigger. The latch is low at all other times.
- R3: pad_clk_o is high whenever the block is idle. After the latch falls, the clock stays high for one half-period (HALF_US). It then gives sixteen pulses, each low for one half-period and then high for one half-period.
- R4: Bit i (i = 0..15) is the level that pad_data_i had in the last cycle before the i-th falling edge of pad_clk_o. For bit 0, that cycle is the last cycle of the gap. The level is taken through SYNC_STAGES flops, and the capture point is delayed to match.
- R5: buttons_o[i] is the inverse of received bit i, so 1 means pressed. Bit 0 holds the first bit received.
- R6: The four trailing positions (bits 12..15) are clocked and captured like all others. An unused position that reads high therefore gives 0 in buttons_o.
- R7: valid_o pulses for one cycle, in the first cycle after the last high phase. buttons_o takes the new word in that same cycle and holds it until the next valid_o.
- R8: busy_o is high from the first latch cycle through the last cycle of the final clock high phase, which is LATCH + 33 half-periods in total. It falls in the cycle where valid_o is high.
- R9: A period counter starts at reset release and fires every CLK_HZ/POLL_HZ cycles. A firing that finds the block idle starts a read. A firing that finds the block busy is dropped.
- R10: start_i high at a clock edge while the block is idle starts a read. start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an immediate read |
| pad_data_i | input | 1 | Serial data from gamepad, low = pressed |
| pad_latch_o | output | 1 | Snapshot strobe to gamepad, idles low |
| pad_clk_o | output | 1 | Shift clock to gamepad, idles high |
| busy_o | output | 1 | Read in progress |
| valid_o | output | 1 | One-cycle strobe: new word on buttons_o |
| buttons_o | output | 16 | Last word read, 1 = pressed, bit 0 first received |

## Verification
A wrong phase counter or state shows up on pad_latch_o or pad_clk_o within one half-period, as a pulse edge that moves by a cycle against the model. A bit index that drifts changes the number of pulses, so busy_o and valid_o move by a whole period. Errors in the sampling point or the synchronizer depth are visible only when the word is published, about 33 half-periods later. They appear as a shifted or swapped buttons_o. The bench drives patterns that are not symmetric so that such a shift cannot pass unseen.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_GAP,
    ST_LOW,
    ST_HIGH
  } seq_state_e;

  function automatic int unsigned us_to_cyc(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction

endpackage

// File: rtl/gp_poll_timer.sv
module gp_poll_timer #(
  parameter int unsigned PERIOD = 833_333
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R9: ticks are isolated pulses, never back to back
  a_r9_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/gp_sequencer.sv
module gp_sequencer
  import gp_pkg::*;
#(
  parameter int unsigned LATCH_CYC   = 600,
  parameter int unsigned HALF_CYC    = 300,
  parameter int unsigned NUM_BITS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic                data_i,
  output logic                latch_o,
  output logic                clk_o,
  output logic                busy_o,
  output logic                valid_o,
  output logic [NUM_BITS-1:0] word_o
);
  localparam int unsigned MAX_PH = (LATCH_CYC > HALF_CYC) ? LATCH_CYC : HALF_CYC;
  localparam int unsigned CW     = $clog2(MAX_PH + 1);
  localparam int unsigned BW     = (NUM_BITS > 2) ? $clog2(NUM_BITS) : 1;
  localparam logic [CW-1:0] LATCH_LAST = CW'(LATCH_CYC - 1);
  localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] CAP_POINT  = CW'(SYNC_STAGES - 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(NUM_BITS - 1);

  seq_state_e          state_q, state_d;
  logic [CW-1:0]       cnt_q;
  logic [BW-1:0]       bit_q;
  logic [NUM_BITS-1:0] shreg_q;
  logic                phase_last, last_bit, capture, done;

  assign phase_last = (state_q == ST_LATCH) ? (cnt_q == LATCH_LAST) : (cnt_q == HALF_LAST);
  assign last_bit   = (bit_q == BIT_LAST);
  // sync output now shows the wire level from the cycle before the falling edge
  assign capture    = (state_q == ST_LOW) && (cnt_q == CAP_POINT);
  assign done       = (state_q == ST_HIGH) && phase_last && last_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_i)       state_d = ST_LATCH;
      ST_LATCH: if (phase_last) state_d = ST_GAP;
      ST_GAP:   if (phase_last) state_d = ST_LOW;
      ST_LOW:   if (phase_last) state_d = ST_HIGH;
      ST_HIGH:  if (phase_last) state_d = last_bit ? ST_IDLE : ST_LOW;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q || state_q == ST_IDLE) cnt_q <= '0;
      else                                          cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   bit_q <= '0;
    else if (state_q == ST_IDLE)                   bit_q <= '0;
    else if (state_q == ST_HIGH && phase_last)     bit_q <= last_bit ? '0 : bit_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shreg_q <= '0;
    else if (capture) shreg_q <= {~data_i, shreg_q[NUM_BITS-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= 1'b0;
      clk_o   <= 1'b1;
      busy_o  <= 1'b0;
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      latch_o <= (state_d == ST_LATCH);
      clk_o   <= (state_d != ST_LOW);
      busy_o  <= (state_d != ST_IDLE);
      valid_o <= done;
      if (done) word_o <= shreg_q;
    end
  end

  // R3: the shift clock never drops while the latch is high
  a_r3_clk_high_in_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> clk_o);
  // R3: an idle link rests with the clock high and the latch low
  a_r3_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (clk_o && !latch_o));
  // R8: the latch only occurs inside a busy window
  a_r8_latch_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> busy_o);
  // R8: busy ends exactly when the word is published
  a_r8_busy_ends_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);
  // R7: single-cycle strobe
  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7: the word holds between strobes
  a_r7_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
  // R10: a latch pulse only starts from idle
  a_r10_launch_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> !$past(busy_o));

endmodule

// File: rtl/gamepad_poller.sv
module gamepad_poller
  import gp_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned POLL_HZ     = 60,
  parameter int unsigned LATCH_US    = 12,
  parameter int unsigned HALF_US     = 6,
  parameter int unsigned NUM_BITS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                pad_data_i,
  output logic                pad_latch_o,
  output logic                pad_clk_o,
  output logic                busy_o,
  output logic                valid_o,
  output logic [NUM_BITS-1:0] buttons_o
);
  localparam int unsigned LATCH_CYC = us_to_cyc(CLK_HZ, LATCH_US);
  localparam int unsigned HALF_CYC  = us_to_cyc(CLK_HZ, HALF_US);
  localparam int unsigned POLL_CYC  = CLK_HZ / POLL_HZ;

  initial begin
    a_cfg_clk: assert (CLK_HZ >= 1_000_000);
    a_cfg_half: assert (HALF_CYC > SYNC_STAGES);
    a_cfg_poll: assert (POLL_CYC >= 2);
  end

  logic tick, data_s;

  gp_poll_timer #(.PERIOD(POLL_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  gp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_data_i),
    .q_o    (data_s)
  );

  gp_sequencer #(
    .LATCH_CYC   (LATCH_CYC),
    .HALF_CYC    (HALF_CYC),
    .NUM_BITS    (NUM_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (start_i | tick),
    .data_i  (data_s),
    .latch_o (pad_latch_o),
    .clk_o   (pad_clk_o),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .word_o  (buttons_o)
  );

  // R2: latch rises only after an idle cycle holding a request
  a_r2_latch_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pad_latch_o) |-> $past(start_i | tick));

endmodule

// File: tb/test_gamepad_poller.sv
module test_gamepad_poller;
  localparam int CLK_HZ = 1_000_000;
  localparam int POLL_HZ = 2000;
  localparam int L = 12;
  localparam int H = 6;
  localparam int P = CLK_HZ / POLL_HZ;
  localparam int T_END = L + 33 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pad_data = 1'b1;
  logic latch_o, pclk_o, busy_o, valid_o;
  logic [15:0] word_o;

  always #10 clk = ~clk;

  gamepad_poller #(.CLK_HZ(CLK_HZ), .POLL_HZ(POLL_HZ)) i_gamepad_poller (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pad_data_i(pad_data),
    .pad_latch_o(latch_o), .pad_clk_o(pclk_o), .busy_o(busy_o),
    .valid_o(valid_o), .buttons_o(word_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // gamepad model
  logic [11:0] pressed = 12'h000;
  logic [15:0] snap = 16'hFFFF;
  logic [15:0] pad_word = 16'h0;
  int idx = 16;
  logic prev_clk = 1'b1;

  // reference model
  int pc = 0;
  bit act = 0;
  int t = 0;
  bit m_valid = 0;
  logic [15:0] m_word = 16'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pc = 0; act = 0; t = 0; m_valid = 0; m_word = 16'h0;
    end else begin
      bit tk;
      tk = (pc == P - 1);
      pc = tk ? 0 : pc + 1;
      m_valid = 0;
      if (!act) begin
        if (start || tk) begin act = 1; t = 0; end  // R9 R10
      end else begin
        t = t + 1;
        if (t == T_END) begin act = 0; m_valid = 1; m_word = pad_word; end
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act_v, input logic [15:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_latch, e_clk;
      cyc++;
      e_latch = act && (t < L);
      e_clk = !(act && t >= L + H && (((t - L - H) / H) % 2 == 0));
      chk("R2 latch", {15'b0, latch_o}, {15'b0, e_latch});
      chk("R3 clock", {15'b0, pclk_o}, {15'b0, e_clk});
      chk("R8/R9/R10 busy", {15'b0, busy_o}, {15'b0, act});
      chk("R7 valid", {15'b0, valid_o}, {15'b0, m_valid});
      chk("R4/R5 word", word_o, m_word);
      if (valid_o) chk("R6 unused bits", {12'b0, word_o[15:12]}, 16'h0);
      if (cyc > 10000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below 10000", cyc);
        done = 1;
      end
    end
    // gamepad behaviour, updated away from the active edge
    if (!rst_n) begin
      idx = 16; prev_clk = 1'b1; pad_data = 1'b1;
    end else begin
      if (latch_o) begin
        snap = {4'hF, ~pressed};
        pad_word = {4'h0, pressed};
        idx = 0;
      end else if (!prev_clk && pclk_o && idx < 16) begin
        idx++;
      end
      prev_clk = pclk_o;
      pad_data = (idx < 16) ? snap[idx] : 1'b0;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    // R1: reset state
    chk("R1 latch", {15'b0, latch_o}, 16'h0);
    chk("R1 clock", {15'b0, pclk_o}, 16'h1);
    chk("R1 busy", {15'b0, busy_o}, 16'h0);
    chk("R1 valid", {15'b0, valid_o}, 16'h0);
    chk("R1 word", word_o, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    // R10: immediate read, single button on the first bit
    pressed = 12'h001;
    wait_cyc(8); pulse_start();
    wait_cyc(90); pulse_start();          // R10 ignored while busy
    wait_cyc(150);
    pressed = 12'hA5C;                    // R9: periodic read picks this up
    wait_cyc(480);
    pressed = 12'hFFF; pulse_start();     // all pressed
    wait_cyc(80); pressed = 12'h000;      // change after snapshot has no effect
    wait_cyc(500);                        // next tick reads none pressed
    wait_cyc(180); pulse_start();         // busy across a tick: tick dropped (R9)
    pressed = 12'h555;
    wait_cyc(700);
    pressed = 12'h8C3;
    @(negedge clk); start = 1'b1;         // back-to-back reads
    wait_cyc(520);
    start = 1'b0;
    wait_cyc(300);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (done);
    if (cyc > 10000) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule